// File: doc/BRIEF.md
# Keyed S-box Leakage Counter

This block is a self-running eight-bit state machine whose state sequence also drives a non-linear lookup. The state machine is a counter. A parameter builds it either as a natural binary counter or as a Gray-code counter. Every cycle the current state is XORed with a constant secret key. The result addresses a 256-entry memory that holds the AES forward substitution table. The byte read from that memory is registered and driven out.

The lookup path adds switching activity that is distinctive for the key and for the counter type. It reads the state and never feeds back into the counter, so the counter's sequence is the same as it would be without the lookup. The block takes no data inputs. Its behaviour depends only on clock, synchronous reset and enable, so repeated runs from reset produce identical sequences with a period of 256 advances.

The substituted byte trails the state by one clock, because the memory read is synchronous. A flag marks when that byte is meaningful.

Top module: `keyed_sbox_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `state` = 0, `subst` = 0 and `subst_valid` = 0.
- R2: With `GRAY` = 0, each rising edge with `en` high and `rst` low adds one to `state`, and 255 wraps to 0.
- R3: With `GRAY` = 1, after n enabled advances since reset `state` equals (n mod 256) XOR ((n mod 256) >> 1). Consecutive states therefore differ in exactly one bit, and the code returns to 0 after 256 advances.
- R4: A rising edge with `en` low leaves `state` unchanged.
- R5: After each rising edge with `rst` low, `subst` equals SBOX(`state` XOR `KEY`), where `state` is the value held before that edge and SBOX is the AES forward substitution: the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapped to 0, followed by the affine map with constant 0x63.
- R6: `subst_valid` goes high at the first rising edge with `rst` low and stays high until the next reset.
- R7: Within any 256 consecutive advances, `state` takes each of the 256 values exactly once, in both counter modes.
- R8: Two instances of the same counter type whose keys differ give a different `subst` on every valid cycle of the same run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the counter on this edge |
| state | output | 8 | Current counter state (binary or Gray code) |
| subst | output | 8 | Registered substitution of the previous state XOR key |
| subst_valid | output | 1 | High once `subst` carries a lookup result |

## Verification
The bench runs three instances side by side: a binary counter, and two Gray counters that differ only in their keys. Holding enable high for a full period of 256 advances shows the wrap, the coverage of all codes, the one-bit Gray steps and every one of the 256 table entries at the output. A stretch with enable held low, and a stretch where enable alternates, separate the counter's advance from the lookup, which still re-reads the same address while the state holds. A reset in the middle of a run, followed by a replay, shows that the sequence starts again from the same state.

// File: rtl/keyed_sbox_counter.sv
module keyed_sbox_counter #(
  parameter bit         GRAY = 1'b0,
  parameter logic [7:0] KEY  = 8'h5A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [7:0] state,
  output logic [7:0] subst,
  output logic       subst_valid
);
  localparam int W     = 8;
  localparam int DEPTH = 1 << W;

  function automatic logic [W-1:0] gf_mul(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] p;
    logic         hi;
    p = '0;
    for (int i = 0; i < W; i++) begin
      if (b[0]) p = p ^ a;
      hi = a[W-1];
      a  = a << 1;
      if (hi) a = a ^ 8'h1b;
      b  = b >> 1;
    end
    return p;
  endfunction

  function automatic logic [W-1:0] gf_inv(logic [W-1:0] x);
    logic [W-1:0] r;
    r = 8'h01;
    for (int i = 0; i < 254; i++) r = gf_mul(r, x);
    return r;
  endfunction

  function automatic logic [W-1:0] rotl(logic [W-1:0] v, int k);
    return (v << k) | (v >> (W - k));
  endfunction

  function automatic logic [W-1:0] sbox_entry(logic [W-1:0] x);
    logic [W-1:0] b;
    b = gf_inv(x);
    return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
  endfunction

  logic [W-1:0] table_mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) table_mem[i] = sbox_entry(W'(i));
  end

  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)     count_q <= '0;
    else if (en) count_q <= count_q + 1'b1;
  end

  generate
    if (GRAY) begin : g_gray
      assign state = count_q ^ (count_q >> 1);
    end else begin : g_bin
      assign state = count_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      subst       <= '0;
      subst_valid <= 1'b0;
    end else begin
      subst       <= table_mem[state ^ KEY];
      subst_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/keyed_sbox_counter_chk.sv
module keyed_sbox_counter_chk #(
  parameter bit GRAY = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [7:0] state,
  input logic [7:0] subst,
  input logic       subst_valid
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (state == 8'd0 && subst == 8'd0 && !subst_valid));

  assert_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> subst_valid);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en |-> ##2 $stable(subst));

  generate
    if (GRAY) begin : g_gray
      assert_one_bit_R3: assert property (@(posedge clk) disable iff (rst)
        en |=> $countones(state ^ $past(state)) == 1);
    end else begin : g_bin
      assert_incr_R2: assert property (@(posedge clk) disable iff (rst)
        en |=> state == $past(state) + 8'd1);
    end
  endgenerate
endmodule

bind keyed_sbox_counter keyed_sbox_counter_chk #(.GRAY(GRAY)) u_chk (
  .clk(clk), .rst(rst), .en(en), .state(state),
  .subst(subst), .subst_valid(subst_valid)
);

// File: tb/test_keyed_sbox_counter.sv
module test_keyed_sbox_counter;
  localparam logic [7:0] KA = 8'hA5;
  localparam logic [7:0] KB = 8'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [7:0] st_b, st_g, st_k, out_b, out_g, out_k;
  logic v_b, v_g, v_k;

  always #4 clk = ~clk;

  keyed_sbox_counter #(.GRAY(1'b0), .KEY(KA)) i_keyed_sbox_counter (
    .clk(clk), .rst(rst), .en(en), .state(st_b), .subst(out_b), .subst_valid(v_b));
  keyed_sbox_counter #(.GRAY(1'b1), .KEY(KA)) i_keyed_sbox_counter_gray (
    .clk(clk), .rst(rst), .en(en), .state(st_g), .subst(out_g), .subst_valid(v_g));
  keyed_sbox_counter #(.GRAY(1'b1), .KEY(KB)) i_keyed_sbox_counter_key (
    .clk(clk), .rst(rst), .en(en), .state(st_k), .subst(out_k), .subst_valid(v_k));

  int checks = 0;
  int fails  = 0;
  logic [7:0] sref [256];
  int n_cur  = 0;
  int n_prev = 0;
  bit was_rst = 1'b1;

  function automatic logic [7:0] pmul(logic [7:0] a, logic [7:0] b);
    logic [14:0] prod;
    prod = '0;
    for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (prod[i]) prod = prod ^ (15'h11b << (i - 8));
    return prod[7:0];
  endfunction

  function automatic logic [7:0] ref_entry(logic [7:0] x);
    logic [7:0] b, s;
    b = 8'h00;
    for (int y = 1; y < 256; y++) if (x != 0 && pmul(x, 8'(y)) == 8'h01) b = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ (((8'h63) >> i) & 1'b1);
    return s;
  endfunction

  function automatic logic [7:0] gcode(int n);
    logic [7:0] b;
    b = 8'(n);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edge_step(bit e);
    en = e;
    @(posedge clk);
    n_prev  = n_cur;
    was_rst = rst;
    if (!rst && e) n_cur++;
    if (rst) n_cur = 0;
    @(negedge clk);
  endtask

  task automatic check_all();
    chk(st_b == 8'(n_cur), "R2", st_b, 8'(n_cur));
    chk(st_g == gcode(n_cur), "R3", st_g, gcode(n_cur));
    chk(st_k == gcode(n_cur), "R3", st_k, gcode(n_cur));
    if (!was_rst) begin
      chk(v_b && v_g && v_k, "R6", {v_b, v_g, v_k}, 3'b111);
      chk(out_b == sref[8'(n_prev) ^ KA], "R5", out_b, sref[8'(n_prev) ^ KA]);
      chk(out_g == sref[gcode(n_prev) ^ KA], "R5", out_g, sref[gcode(n_prev) ^ KA]);
      chk(out_k == sref[gcode(n_prev) ^ KB], "R5", out_k, sref[gcode(n_prev) ^ KB]);
      chk(out_g != out_k, "R8", out_g, out_k);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    edge_step(1'b1);
    edge_step(1'b1);
    chk(st_b == 0 && st_g == 0 && st_k == 0, "R1", st_b | st_g | st_k, 0);
    chk(out_b == 0 && out_g == 0 && out_k == 0, "R1", out_b | out_g | out_k, 0);
    chk(!v_b && !v_g && !v_k, "R1", {v_b, v_g, v_k}, 0);
  endtask

  task automatic t_first_valid();
    rst = 1'b0;
    edge_step(1'b0);
    chk(v_b == 1'b1, "R6", v_b, 1);
    chk(out_b == sref[KA], "R5", out_b, sref[KA]);
    check_all();
  endtask

  task automatic t_hold();
    for (int i = 0; i < 5; i++) begin
      edge_step(1'b0);
      chk(st_b == 8'(n_cur) && n_cur == n_prev, "R4", st_b, 8'(n_prev));
      check_all();
    end
  endtask

  task automatic t_full_period();
    bit seen_b [256];
    bit seen_g [256];
    logic [7:0] last_g;
    int start;
    start = n_cur;
    for (int i = 0; i < 256; i++) begin seen_b[i] = 0; seen_g[i] = 0; end
    for (int i = 0; i < 256; i++) begin
      last_g = st_g;
      seen_b[st_b] = 1;
      seen_g[st_g] = 1;
      edge_step(1'b1);
      chk($countones(st_g ^ last_g) == 1, "R3", st_g ^ last_g, 1);
      check_all();
    end
    for (int i = 0; i < 256; i++) begin
      chk(seen_b[i], "R7", i, 1);
      chk(seen_g[i], "R7", i, 1);
    end
    chk(st_b == 8'(start) && st_g == gcode(start), "R7", st_b, 8'(start));
  endtask

  task automatic t_wrap();
    while (8'(n_cur) != 8'hFF) edge_step(1'b1);
    check_all();
    edge_step(1'b1);
    chk(st_b == 8'h00, "R2", st_b, 0);
    chk(st_g == 8'h00, "R3", st_g, 0);
    check_all();
  endtask

  task automatic t_toggle();
    for (int i = 0; i < 40; i++) begin
      edge_step(i[0]);
      check_all();
    end
  endtask

  task automatic t_mid_reset();
    logic [7:0] first_run [10];
    rst = 1'b1;
    edge_step(1'b1);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin edge_step(1'b1); first_run[i] = out_g; check_all(); end
    for (int i = 0; i < 7; i++) edge_step(1'b1);
    rst = 1'b1;
    edge_step(1'b1);
    chk(st_b == 0 && st_g == 0 && !v_g, "R1", st_g, 0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      edge_step(1'b1);
      chk(out_g == first_run[i], "R1", out_g, first_run[i]);
      check_all();
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) sref[i] = ref_entry(8'(i));
    chk(sref[8'h00] == 8'h63 && sref[8'h01] == 8'h7c && sref[8'h53] == 8'hed,
        "R5", sref[8'h53], 8'hed);
    @(negedge clk);
    t_reset();
    t_first_valid();
    t_hold();
    t_full_period();
    t_wrap();
    t_toggle();
    t_mid_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule